// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block recovers asynchronous serial frames from a single receive line. A free-running strobe arrives at sixteen times the bit rate, and the line is read once on each strobe. Each bit slot produces one value, taken as the majority of the three samples around the middle of the slot. A frame has a start bit, a data field of 8 or 9 bits sent least significant bit first, and one or two stop bits. When parity is enabled, the most significant bit of the field is the parity bit.

When the frame is complete, the word goes into a one-entry receive buffer and a one-cycle receive pulse is raised. Any framing, parity or overrun condition is reported in flags and in a one-cycle error pulse. The baud strobe comes from outside, and the line is assumed to be already synchronous to `clk_i`.

Top module: `rx_os_receiver`

## Requirements
- R1: A frame starts only on a strobe where the line is 0 and was 1 on the previous strobe, while both `run_en_i` and `rx_en_i` are 1. Otherwise no word is produced.
- R2: Each bit value is the majority of samples 7, 8 and 9 of its slot, where the start-edge strobe is sample 1. A single deviating sample among the three has no effect.
- R3: If the voted start bit is 1, the frame is dropped with no pulse, and the next falling edge starts a new frame normally.
- R4: Data bits are assembled least significant bit first. With `nine_bit_i`=1 the field is 9 bits and fills `rbuf_o[8:0]`. With `nine_bit_i`=0 it is 8 bits in `rbuf_o[7:0]`, and `rbuf_o[8]` is 0.
- R5: `two_stop_i` selects one or two stop bits. The word is written and `rx_pulse_o` is high for exactly one cycle, right after the strobe carrying sample 9 of the last stop bit, and not before.
- R6: The word is delivered whether or not the stop bits are valid. `frame_err_o` is 1 if any stop bit of that frame voted 0.
- R7: With `parity_en_i`=1, `parity_err_o` is 1 when the XOR of all field bits (parity bit included) is 1, which is even parity. With parity disabled it stays 0.
- R8: A word that arrives while the buffer holds an unread word sets `overrun_o` and replaces the old word. `rd_i` empties the buffer, and a read in the same cycle as an arrival counts first.
- R9: Clearing `rx_en_i` during a frame lets that frame complete with its pulses. Later start bits are not accepted while it stays 0.
- R10: `err_pulse_o` is high in the same cycle as `rx_pulse_o` exactly when `frame_err_o`, `parity_err_o` or `overrun_o` is set for that word.
- R11: After reset `rbuf_o` is 0, all flags and pulses are 0, and the receiver is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick16_i | input | 1 | Sample strobe at 16x bit rate |
| run_en_i | input | 1 | Block run enable |
| rx_en_i | input | 1 | Receive enable, gates new frames |
| nine_bit_i | input | 1 | 1: 9-bit data field, 0: 8-bit |
| parity_en_i | input | 1 | Field MSB is even parity bit |
| two_stop_i | input | 1 | 1: two stop bits |
| rx_i | input | 1 | Serial receive line |
| rd_i | input | 1 | Buffer read, empties the buffer |
| rbuf_o | output | 9 | Received word |
| rx_pulse_o | output | 1 | One-cycle word-received pulse |
| err_pulse_o | output | 1 | One-cycle error pulse |
| frame_err_o | output | 1 | Stop bit voted 0 in last word |
| parity_err_o | output | 1 | Parity mismatch in last word |
| overrun_o | output | 1 | Last word overwrote an unread one |

## Verification
The sample counter can drift. If it does, the vote lands on the wrong samples, so glitches at samples 8 or 9 corrupt `rbuf_o`, or `rx_pulse_o` shifts away from sample 9 of the last stop bit. Either shows up at the first completed frame. A frame state machine stuck outside idle shows as missing pulses on every later frame. One stuck in idle shows as frames accepted after a false start or after the enable is cleared, which is visible one frame time after the stimulus. Stale error accumulators show as wrong flags on the very next word.

// File: rtl/rx_os_pkg.sv
package rx_os_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_e;
endpackage

// File: rtl/rx_os_sampler.sv
module rx_os_sampler #(
  parameter int unsigned OVS = 16,
  parameter int unsigned MID = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic rx_i,
  input  logic sync_i,
  output logic edge_o,
  output logic vote_stb_o,
  output logic vote_o
);
  localparam int unsigned CW = $clog2(OVS) + 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] idx;
  logic          smp_a_q, smp_b_q, rx_prev_q;

  // idx: number of this strobe's sample within the current slot
  assign idx = cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      smp_a_q   <= 1'b1;
      smp_b_q   <= 1'b1;
      rx_prev_q <= 1'b1;
    end else if (tick_i) begin
      rx_prev_q <= rx_i;
      if (sync_i)                cnt_q <= CW'(1);
      else if (idx == CW'(OVS))  cnt_q <= '0;
      else                       cnt_q <= idx;
      if (idx == CW'(MID - 1)) smp_a_q <= rx_i;
      if (idx == CW'(MID))     smp_b_q <= rx_i;
    end
  end

  assign edge_o     = tick_i & rx_prev_q & ~rx_i;
  assign vote_stb_o = tick_i & ~sync_i & (idx == CW'(MID + 1));
  assign vote_o     = (smp_a_q & smp_b_q) | (smp_a_q & rx_i) | (smp_b_q & rx_i);
endmodule

// File: rtl/rx_os_frame.sv
module rx_os_frame
  import rx_os_pkg::*;
#(
  parameter int unsigned DW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          vote_stb_i,
  input  logic          vote_i,
  input  logic          nine_i,
  input  logic          par_i,
  input  logic          two_i,
  output logic          sync_o,
  output logic          done_o,
  output logic [DW-1:0] word_o,
  output logic          fe_o,
  output logic          pe_o
);
  localparam int unsigned BCW = $clog2(DW);
  localparam logic [BCW-1:0] LAST_LONG  = BCW'(DW - 1);
  localparam logic [BCW-1:0] LAST_SHORT = BCW'(DW - 2);

  rx_state_e      state_q;
  logic [DW-1:0]  sr_q;
  logic [BCW-1:0] bit_q;
  logic           stop_more_q, fe_acc_q, nine_q, par_q;
  logic [BCW-1:0] last_bit;

  assign last_bit = nine_q ? LAST_LONG : LAST_SHORT;
  assign sync_o   = (state_q == ST_IDLE) & start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      sr_q        <= '0;
      bit_q       <= '0;
      stop_more_q <= 1'b0;
      fe_acc_q    <= 1'b0;
      nine_q      <= 1'b0;
      par_q       <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (sync_o) begin
          state_q     <= ST_START;
          nine_q      <= nine_i;   // mode frozen for the whole frame
          par_q       <= par_i;
          stop_more_q <= two_i;
          fe_acc_q    <= 1'b0;
          bit_q       <= '0;
        end
        ST_START: if (vote_stb_i) state_q <= vote_i ? ST_IDLE : ST_DATA;
        ST_DATA: if (vote_stb_i) begin
          sr_q <= {vote_i, sr_q[DW-1:1]};
          if (bit_q == last_bit) state_q <= ST_STOP;
          else                   bit_q   <= bit_q + 1'b1;
        end
        ST_STOP: if (vote_stb_i) begin
          fe_acc_q <= fe_acc_q | ~vote_i;
          if (stop_more_q) stop_more_q <= 1'b0;
          else             state_q     <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o = (state_q == ST_STOP) & vote_stb_i & ~stop_more_q;
  assign word_o = nine_q ? sr_q : {1'b0, sr_q[DW-1:1]};
  assign fe_o   = fe_acc_q | ~vote_i;
  assign pe_o   = par_q & (^word_o);
endmodule

// File: rtl/rx_os_buffer.sv
module rx_os_buffer #(
  parameter int unsigned DW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          done_i,
  input  logic [DW-1:0] word_i,
  input  logic          fe_i,
  input  logic          pe_i,
  input  logic          rd_i,
  output logic [DW-1:0] rbuf_o,
  output logic          fe_o,
  output logic          pe_o,
  output logic          oe_o,
  output logic          pulse_o,
  output logic          err_o
);
  logic full_q;
  logic ovr;

  // a read in the arrival cycle frees the entry first
  assign ovr = full_q & ~rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbuf_o  <= '0;
      fe_o    <= 1'b0;
      pe_o    <= 1'b0;
      oe_o    <= 1'b0;
      pulse_o <= 1'b0;
      err_o   <= 1'b0;
      full_q  <= 1'b0;
    end else begin
      pulse_o <= done_i;
      err_o   <= done_i & (fe_i | pe_i | ovr);
      if (done_i) begin
        rbuf_o <= word_i;
        fe_o   <= fe_i;
        pe_o   <= pe_i;
        oe_o   <= ovr;
        full_q <= 1'b1;
      end else if (rd_i) begin
        full_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rx_os_receiver.sv
module rx_os_receiver #(
  parameter int unsigned DW  = 9,
  parameter int unsigned OVS = 16,
  parameter int unsigned MID = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick16_i,
  input  logic          run_en_i,
  input  logic          rx_en_i,
  input  logic          nine_bit_i,
  input  logic          parity_en_i,
  input  logic          two_stop_i,
  input  logic          rx_i,
  input  logic          rd_i,
  output logic [DW-1:0] rbuf_o,
  output logic          rx_pulse_o,
  output logic          err_pulse_o,
  output logic          frame_err_o,
  output logic          parity_err_o,
  output logic          overrun_o
);
  logic          edge_w, vote_stb_w, vote_w, sync_w, done_w, fe_w, pe_w;
  logic [DW-1:0] word_w;

  rx_os_sampler #(.OVS(OVS), .MID(MID)) u_sampler (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick16_i),
    .rx_i       (rx_i),
    .sync_i     (sync_w),
    .edge_o     (edge_w),
    .vote_stb_o (vote_stb_w),
    .vote_o     (vote_w)
  );

  rx_os_frame #(.DW(DW)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (edge_w & run_en_i & rx_en_i),
    .vote_stb_i (vote_stb_w),
    .vote_i     (vote_w),
    .nine_i     (nine_bit_i),
    .par_i      (parity_en_i),
    .two_i      (two_stop_i),
    .sync_o     (sync_w),
    .done_o     (done_w),
    .word_o     (word_w),
    .fe_o       (fe_w),
    .pe_o       (pe_w)
  );

  rx_os_buffer #(.DW(DW)) u_buffer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .done_i  (done_w),
    .word_i  (word_w),
    .fe_i    (fe_w),
    .pe_i    (pe_w),
    .rd_i    (rd_i),
    .rbuf_o  (rbuf_o),
    .fe_o    (frame_err_o),
    .pe_o    (parity_err_o),
    .oe_o    (overrun_o),
    .pulse_o (rx_pulse_o),
    .err_o   (err_pulse_o)
  );
endmodule

// File: rtl/rx_os_receiver_chk.sv
module rx_os_receiver_chk #(
  parameter int unsigned DW = 9
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          parity_en_i,
  input logic [DW-1:0] rbuf_o,
  input logic          rx_pulse_o,
  input logic          err_pulse_o,
  input logic          frame_err_o,
  input logic          parity_err_o,
  input logic          overrun_o
);
  a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pulse_o |=> !rx_pulse_o);

  a_r5_rbuf_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_pulse_o |-> $stable(rbuf_o));

  a_r10_err_with_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_pulse_o |-> rx_pulse_o);

  a_r10_err_matches_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pulse_o |-> (err_pulse_o == (frame_err_o | parity_err_o | overrun_o)));

  a_r8_overrun_on_arrival: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> rx_pulse_o);

  a_r7_no_parity_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_pulse_o && !$past(parity_en_i)) |-> !parity_err_o);
endmodule

bind rx_os_receiver rx_os_receiver_chk #(.DW(DW)) u_chk (.*);

// File: tb/rx_os_receiver_bench.sv
`timescale 1ns/1ps
module rx_os_receiver_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] pre = '0;
  logic       run_en = 1'b1, rx_en = 1'b1, nine = 1'b0, par = 1'b0, two = 1'b0;
  logic       rx = 1'b1, rd = 1'b0;
  logic [8:0] rbuf;
  logic       rx_pulse, err_pulse, fe, pe, oe;
  int         checks = 0, errors = 0, npulse = 0;
  bit         finished = 1'b0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    pre  <= pre + 1'b1;
    tick <= (pre == 2'd3);
    if (rx_pulse) npulse <= npulse + 1;
  end

  rx_os_receiver u_rx_os_receiver (
    .clk_i(clk), .rst_ni(rst_n), .tick16_i(tick), .run_en_i(run_en),
    .rx_en_i(rx_en), .nine_bit_i(nine), .parity_en_i(par), .two_stop_i(two),
    .rx_i(rx), .rd_i(rd), .rbuf_o(rbuf), .rx_pulse_o(rx_pulse),
    .err_pulse_o(err_pulse), .frame_err_o(fe), .parity_err_o(pe), .overrun_o(oe)
  );

  // {nine,par,two,bad1,bad2,field[8:0],exp_word[8:0],exp_fe,exp_pe}
  localparam logic [24:0] VEC [8] = '{
    {1'b0,1'b0,1'b0,1'b0,1'b0,9'h0A5,9'h0A5,1'b0,1'b0},
    {1'b1,1'b0,1'b0,1'b0,1'b0,9'h1C3,9'h1C3,1'b0,1'b0},
    {1'b0,1'b1,1'b0,1'b0,1'b0,9'h083,9'h083,1'b0,1'b1},
    {1'b1,1'b1,1'b1,1'b0,1'b0,9'h0F0,9'h0F0,1'b0,1'b0},
    {1'b0,1'b0,1'b0,1'b0,1'b1,9'h03C,9'h03C,1'b1,1'b0},
    {1'b0,1'b0,1'b1,1'b1,1'b0,9'h07E,9'h07E,1'b1,1'b0},
    {1'b1,1'b1,1'b0,1'b0,1'b0,9'h155,9'h155,1'b0,1'b1},
    {1'b0,1'b0,1'b0,1'b0,1'b0,9'h1FF,9'h0FF,1'b0,1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // consume one strobe with the line at v
  task automatic one_sample(input logic v);
    rx = v;
    @(negedge clk);
    while (!tick) @(negedge clk);
    @(posedge clk);
    #1;
  endtask

  task automatic drive_slot(input logic v, input int lo, input int hi);
    for (int i = 1; i <= 16; i++) one_sample((i >= lo && i <= hi) ? ~v : v);
  endtask

  // returns right after sample 9 of the last stop bit
  task automatic send_frame(input logic [8:0] f, input bit nb, input bit pb,
                            input bit tb, input bit s1, input bit s2,
                            input int g, input bit dis);
    one_sample(1'b1);
    nine = nb; par = pb; two = tb;
    drive_slot(1'b0, 0, 0);
    if (dis) rx_en = 1'b0;
    for (int i = 0; i < (nb ? 9 : 8); i++) drive_slot(f[i], g, g);
    if (tb) drive_slot(s1, 0, 0);
    for (int i = 1; i <= 8; i++) one_sample(s2);
    check("R5 no pulse before sample 9", rx_pulse, 0);
    one_sample(s2);
  endtask

  task automatic tail();
    for (int i = 0; i < 7 + 16; i++) one_sample(1'b1);
  endtask

  task automatic read_buf();
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    check("R11 rbuf", rbuf, 0);
    check("R11 pulses", {rx_pulse, err_pulse}, 0);
    check("R11 flags", {fe, pe, oe}, 0);
    tail();

    // table: R4 R5 R6 R7 R10
    for (int i = 0; i < 8; i++) begin
      logic [24:0] v;
      v = VEC[i];
      send_frame(v[19:11], v[24], v[23], v[22], ~v[21], ~v[20], 0, 1'b0);
      check("R5 pulse", rx_pulse, 1);
      check("R4 word", rbuf, v[10:2]);
      check("R6 frame err", fe, v[1]);
      check("R7 parity err", pe, v[0]);
      check("R8 no overrun", oe, 0);
      check("R10 err pulse", err_pulse, v[1] | v[0]);
      tail();
      read_buf();
    end

    // R2 majority: one deviating sample among 7,8,9
    send_frame(9'h05A, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8, 1'b0);
    check("R2 glitch at sample 8", rbuf, 9'h05A);
    tail(); read_buf();
    send_frame(9'h0C9, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 9, 1'b0);
    check("R2 glitch at sample 9", rbuf, 9'h0C9);
    tail(); read_buf();

    // R3 false start: low for samples 1..7 only
    n = npulse;
    one_sample(1'b1);
    drive_slot(1'b1, 1, 7);
    tail(); tail();
    check("R3 false start no word", npulse - n, 0);
    send_frame(9'h096, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 0, 1'b0);
    check("R3 recovery word", rbuf, 9'h096);
    tail(); read_buf();

    // R1 enables gate start
    n = npulse;
    rx_en = 1'b0;
    send_frame(9'h011, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 0, 1'b0);
    tail();
    check("R1 rx_en low ignored", npulse - n, 0);
    rx_en = 1'b1; run_en = 1'b0;
    send_frame(9'h022, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 0, 1'b0);
    tail();
    check("R1 run_en low ignored", npulse - n, 0);
    check("R1 rbuf untouched", rbuf, 9'h096);
    run_en = 1'b1;

    // R9 disable during frame
    send_frame(9'h0E1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 0, 1'b1);
    check("R9 frame completes", rx_pulse, 1);
    check("R9 word", rbuf, 9'h0E1);
    tail(); read_buf();
    n = npulse;
    send_frame(9'h044, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 0, 1'b0);
    tail();
    check("R9 later start ignored", npulse - n, 0);
    rx_en = 1'b1;

    // R8 overrun
    send_frame(9'h011, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 0, 1'b0);
    tail();
    send_frame(9'h022, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 0, 1'b0);
    check("R8 overrun set", oe, 1);
    check("R8 new word replaces", rbuf, 9'h022);
    check("R10 err on overrun", err_pulse, 1);
    tail(); read_buf();
    send_frame(9'h033, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 0, 1'b0);
    check("R8 read clears", oe, 0);
    check("R10 no err", err_pulse, 0);
    tail();
    @(negedge clk);
    check("R5 pulse one cycle", rx_pulse, 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule